// File: doc/BRIEF.md
# Programmable-Order FIFO Word Serializer

This block drains 32-bit words from a transmit FIFO and turns each one into a serial bit stream. The order in which bits leave is not fixed. Up to four packing operations, each a 10-bit vector, name a starting bit index, a walking direction, a bit count and a stop flag. The operations run in order on every word. Several narrow protocol words can therefore be packed into one FIFO entry, or one wide protocol word can be spread over several operations, with either bit order.

Both data interfaces are valid/ready. On the input side a word is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while no word is being shifted, so the FIFO is read again only after the final operation has emitted its last bit. On the output side a bit is consumed on a cycle where `bit_valid` and `bit_ready` are both high. While `bit_ready` is low the current bit, its strobe and its boundary marker hold. The two configuration inputs are plain levels, and they are captured together with each word.

Top module: `fifo_word_unpacker`

## Requirements
- R1: After reset `bit_valid` and `word_end` are low and `in_ready` is high.
- R2: A vector has its start index in bits [9:5], its direction in bit 4, its length-minus-one in bits [3:1] and its stop flag in bit 0. `cfg_lo` holds vector 0 in [9:0] and vector 1 in [19:10]. `cfg_hi` holds vectors 2 and 3 in the same places.
- R3: An operation with length field L emits L+1 bits of the captured word, starting at the start index. With direction 1 the index falls by one per bit; with direction 0 it rises by one per bit.
- R4: Operations run from vector 0 upward. The first vector whose stop flag is set is the last one applied to the word, and every vector after it has no effect on the output.
- R5: When no vector has its stop flag set, all four operations run, and vector 3 is the last.
- R6: `word_end` is high together with the last bit of every operation and low on every other bit.
- R7: `in_ready` is high only while the block is idle. The first bit of an accepted word is valid in the next cycle. `in_ready` stays low until the last bit of the last operation has been consumed.
- R8: While `bit_valid` is high and `bit_ready` is low, `bit_valid`, `bit_out` and `word_end` hold their values.
- R9: The configuration is captured in the cycle a word is accepted. A change of `cfg_lo` or `cfg_hi` while a word is being shifted does not affect that word and applies from the next word.
- R10: While the FIFO offers no word, `bit_valid` stays low.
- R11: Bit indices wrap modulo 32. Walking down from index 0 continues at 31, and walking up from 31 continues at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | FIFO offers a word |
| in_ready | output | 1 | Block takes the offered word this cycle |
| in_data | input | 32 | FIFO word |
| cfg_lo | input | 20 | Packing vectors 0 (low half) and 1 (high half) |
| cfg_hi | input | 20 | Packing vectors 2 (low half) and 3 (high half) |
| bit_valid | output | 1 | `bit_out` carries a valid bit |
| bit_ready | input | 1 | Downstream takes the bit this cycle |
| bit_out | output | 1 | Serial data bit |
| word_end | output | 1 | Current bit is the last bit of an operation |

## Verification
The main function is driven with several layouts:
- four 7-bit words per entry, MSB first, which tells apart per-operation start offsets and boundary markers;
- two 15-bit words, LSB first, which separates the two walking directions and unequal lengths;
- a 23-bit word over three operations, which checks the chaining of one protocol word across vectors;
- a layout with no stop flag, which shows that all four vectors run.

A stop flag on vector 0 or vector 1, with the later vectors filled with non-zero values, shows that those vectors are ignored. A start at bit 1 walking down shows the index wrap. Output stalls in a fixed rhythm separate correct holding from lost or repeated bits. A configuration change in the middle of a word tells capture-at-accept apart from live decoding.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_OPS   = 4;
  localparam int VEC_W     = 10;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int OP_W      = $clog2(NUM_OPS);
  localparam int LEN_W     = 3;
  localparam int CFG_W     = 2 * VEC_W;
  localparam int ALL_W     = NUM_OPS * VEC_W;
  // field positions inside one packing vector
  localparam int STOP_BIT  = 0;
  localparam int LEN_LSB   = 1;
  localparam int DIR_BIT   = 4;
  localparam int START_LSB = 5;

  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} unpk_state_t;
endpackage

// File: rtl/unpk_last_sel.sv
module unpk_last_sel
  import unpk_pkg::*;
(
  input  logic [ALL_W-1:0] vecs_flat,
  output logic [OP_W-1:0]  last_op
);
  logic [NUM_OPS-1:0] stop_flags;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_stop
    assign stop_flags[g] = vecs_flat[g*VEC_W + STOP_BIT];
  end

  // lowest-numbered stop flag wins; none set selects the final vector
  always_comb begin
    last_op = OP_W'(NUM_OPS - 1);
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (stop_flags[i]) last_op = OP_W'(i);
    end
  end
endmodule

// File: rtl/unpk_walker.sv
module unpk_walker
  import unpk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_pos,
  input  logic             step,
  input  logic             walk_down,
  input  logic [LEN_W-1:0] len_m1,
  output logic [IDX_W-1:0] pos,
  output logic             last_bit
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pos   <= load_pos;
      cnt_q <= '0;
    end else if (step) begin
      pos   <= walk_down ? pos - 1'b1 : pos + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_bit = (cnt_q == len_m1);
endmodule

// File: rtl/fifo_word_unpacker.sv
module fifo_word_unpacker
  import unpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [CFG_W-1:0]  cfg_lo,
  input  logic [CFG_W-1:0]  cfg_hi,
  output logic              bit_valid,
  input  logic              bit_ready,
  output logic              bit_out,
  output logic              word_end
);
  unpk_state_t       state_q;
  logic [WORD_W-1:0] word_q;
  logic [ALL_W-1:0]  vecs_q;
  logic [ALL_W-1:0]  vecs_in;
  logic [OP_W-1:0]   op_q, op_nx, last_q, last_in;
  logic [VEC_W-1:0]  cur_vec, nxt_vec, first_vec;
  logic [IDX_W-1:0]  pos, load_pos;
  logic              busy, accept, fire, last_bit, op_done, word_done;
  logic              load, step;

  assign vecs_in   = {cfg_hi, cfg_lo};
  assign busy      = (state_q == ST_SHIFT);
  assign accept    = in_valid && !busy;
  assign fire      = busy && bit_ready;
  assign op_done   = fire && last_bit;
  assign word_done = op_done && (op_q == last_q);
  assign op_nx     = op_q + 1'b1;

  assign cur_vec   = vecs_q[op_q*VEC_W +: VEC_W];
  assign nxt_vec   = vecs_q[op_nx*VEC_W +: VEC_W];
  assign first_vec = vecs_in[VEC_W-1:0];

  assign load     = accept || (op_done && !word_done);
  assign load_pos = accept ? first_vec[START_LSB +: IDX_W]
                           : nxt_vec[START_LSB +: IDX_W];
  assign step     = fire && !last_bit;

  unpk_last_sel u_last (
    .vecs_flat (vecs_in),
    .last_op   (last_in)
  );

  unpk_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_pos  (load_pos),
    .step      (step),
    .walk_down (cur_vec[DIR_BIT]),
    .len_m1    (cur_vec[LEN_LSB +: LEN_W]),
    .pos       (pos),
    .last_bit  (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      vecs_q  <= '0;
      op_q    <= '0;
      last_q  <= '0;
    end else if (accept) begin
      state_q <= ST_SHIFT;
      word_q  <= in_data;
      vecs_q  <= vecs_in;
      op_q    <= '0;
      last_q  <= last_in;
    end else if (word_done) begin
      state_q <= ST_IDLE;
    end else if (op_done) begin
      op_q    <= op_nx;
    end
  end

  assign in_ready  = !busy;
  assign bit_valid = busy;
  assign bit_out   = word_q[pos];
  assign word_end  = busy && last_bit;
endmodule

// File: rtl/unpk_checker.sv
module unpk_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic bit_valid,
  input logic bit_ready,
  input logic bit_out,
  input logic word_end
);
  assert_first_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> bit_valid);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_out) && $stable(word_end)));

  assert_end_in_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> bit_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !in_valid) |=> !bit_valid);
endmodule

bind fifo_word_unpacker unpk_checker u_chk (.*);

// File: tb/fifo_word_unpacker_bench.sv
module fifo_word_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [19:0] cfg_lo = '0;
  logic [19:0] cfg_hi = '0;
  logic        bit_valid;
  logic        bit_ready = 1'b0;
  logic        bit_out;
  logic        word_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fifo_word_unpacker u_fifo_word_unpacker (.*);

  typedef struct packed {
    logic [19:0] lo;
    logic [19:0] hi;
    logic [31:0] data;
    logic        stall;
    logic [7:0]  nbits;
  } row_t;

  // rows: 23-bit MSB first over 3 ops; four 7-bit MSB first; two 15-bit LSB first;
  // no stop flag; stop on op0 with junk after; wrap below bit 0; stop on op1
  localparam int ROWS = 7;
  localparam row_t TABLE [ROWS] = '{
    '{20'h77ADE, 20'h000DD, 32'h0051_3CA7, 1'b0, 8'd23},
    '{20'h770DC, 20'hF76DC, 32'hDEAD_BEEF, 1'b1, 8'd28},
    '{20'h4300E, 20'hC360E, 32'h1234_5678, 1'b0, 8'd30},
    '{20'h03BFE, 20'hA4106, 32'hF0F0_0FF0, 1'b1, 8'd21},
    '{20'hFF869, 20'hFFBFE, 32'h0000_00A8, 1'b0, 8'd5},
    '{20'h00037, 20'h00000, 32'h8000_0001, 1'b1, 8'd4},
    '{20'hFD40E, 20'hFFFFF, 32'hC3A5_5A3C, 1'b0, 8'd11}
  };

  function automatic string row_tag(input int i);
    case (i)
      3:       return "R5";
      4:       return "R4";
      5:       return "R11";
      6:       return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference from the requirements: ordered vectors, stop flag, direction, wrap
  function automatic void model(input logic [19:0] lo, input logic [19:0] hi,
                                input logic [31:0] d, output logic [31:0] b,
                                output logic [31:0] e, output int n);
    logic [39:0] all;
    logic [9:0]  v;
    logic [4:0]  idx;
    int          last;
    all = {hi, lo};
    b = '0; e = '0; n = 0; last = 3;
    for (int i = 3; i >= 0; i--) if (all[i*10]) last = i;
    for (int op = 0; op <= last; op++) begin
      v = all[op*10 +: 10];
      for (int k = 0; k <= int'(v[3:1]); k++) begin
        idx = v[4] ? v[9:5] - 5'(k) : v[9:5] + 5'(k);
        b[n] = d[idx];
        e[n] = (k == int'(v[3:1]));
        n++;
      end
    end
  endfunction

  task automatic run_word(input logic [19:0] lo, input logic [19:0] hi,
                          input logic [19:0] alt_lo, input logic [19:0] alt_hi,
                          input logic [31:0] d, input logic stall,
                          input int nbits, input string tag);
    logic [31:0] eb, ee, gb, ge;
    int          en, n;
    logic        rdy, prev_stall, pb, pe, busy_ok;
    model(lo, hi, d, eb, ee, en);
    gb = '0; ge = '0; n = 0; prev_stall = 1'b0; pb = 1'b0; pe = 1'b0; busy_ok = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; cfg_lo = lo; cfg_hi = hi; bit_ready = 1'b0;
    check(in_ready == 1'b1, {"R7 ready when idle ", tag}, 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0; cfg_lo = alt_lo; cfg_hi = alt_hi;
    check(bit_valid == 1'b1, {"R7 first bit next cycle ", tag}, 32'(bit_valid), 32'd1);
    for (int it = 0; it < 200; it++) begin
      if (!bit_valid) break;
      if (in_ready) busy_ok = 1'b0;
      if (prev_stall)
        check(bit_out == pb && word_end == pe, {"R8 hold under stall ", tag},
              {30'd0, bit_out, word_end}, {30'd0, pb, pe});
      rdy = !(stall && (it % 3 == 1));
      bit_ready = rdy;
      if (rdy) begin
        if (n < 32) begin
          gb[n] = bit_out;
          ge[n] = word_end;
        end
        n++;
      end
      prev_stall = !rdy; pb = bit_out; pe = word_end;
      @(negedge clk);
    end
    bit_ready = 1'b0;
    check(busy_ok, {"R7 no ready while shifting ", tag}, 32'(busy_ok), 32'd1);
    check(n == nbits, {"R4 bit count ", tag}, 32'(n), 32'(nbits));
    check(gb == eb, {"R3 bit stream ", tag}, gb, eb);
    check(ge == ee, {"R6 boundary marks ", tag}, ge, ee);
    check(in_ready == 1'b1, {"R7 ready after last bit ", tag}, 32'(in_ready), 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(bit_valid == 1'b0, "R1 bit_valid after reset", 32'(bit_valid), 32'd0);
    check(word_end == 1'b0, "R1 word_end after reset", 32'(word_end), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

    // table walk: R2 layouts, R3 order, R4/R5 stop handling, R11 wrap
    for (int i = 0; i < ROWS; i++) begin
      run_word(TABLE[i].lo, TABLE[i].hi, TABLE[i].lo, TABLE[i].hi,
               TABLE[i].data, TABLE[i].stall, int'(TABLE[i].nbits),
               $sformatf("%s row %0d", row_tag(i), i));
    end

    // R10 empty FIFO: no output
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(bit_valid == 1'b0, "R10 idle while FIFO empty", 32'(bit_valid), 32'd0);
    end

    // R9 configuration change mid-word applies only to the next word
    run_word(TABLE[0].lo, TABLE[0].hi, TABLE[1].lo, TABLE[1].hi,
             32'h7E5A_9C31, 1'b1, 23, "R9 old cfg kept");
    run_word(TABLE[1].lo, TABLE[1].hi, TABLE[1].lo, TABLE[1].hi,
             32'h7E5A_9C31, 1'b0, 28, "R9 new cfg used");

    finish_run();
  end
endmodule